// File: doc/BRIEF.md
# Two-Way Set-Associative Address Translation Buffer

This block holds recently used virtual-to-physical page translations. A 40-bit virtual address is presented on the lookup port. The virtual page number is split into a set index and a tag. Both ways of the indexed set are compared at once, and the result comes back in the same cycle. That result is a hit flag, the physical page number, the full 36-bit physical address and a rights violation flag. The 14-bit page offset passes through unchanged, which gives 16 KiB pages.

A page table walker fills the buffer after a miss through a refill port. The walker delivers a virtual page number, its physical page number and its access rights. The buffer picks the way to replace.

Each entry keeps three status bits: valid, dirty and referenced. The referenced bit is set whenever the entry is used, and the dirty bit is set when a permitted write hits the entry. The status bits of the entry that hit are reported on the lookup port. A periodic clear command drops every referenced bit. A flush input invalidates the whole buffer when the operating context changes.

Top module: `tlb_sa`

## Requirements
- R1: `hit` is 1 only when `lookupValid` is 1 and one valid entry of the indexed set holds the looked-up tag. On a miss, `lookupPpn`, `lookupPa`, `violation`, `hitDirty` and `hitRef` are all 0.
- R2: The address fields are laid out as follows: offset `lookupVa[13:0]`, set index `lookupVa[21:14]` (the virtual page number modulo 256), and tag `lookupVa[39:22]`. On a hit, `lookupPpn` is the stored physical page number and `lookupPa` is that number concatenated with the unchanged offset.
- R3: A hit sets the referenced bit of the entry at the next clock edge. `clearRef` clears every referenced bit at the next edge. When a hit and `clearRef` occur in the same cycle, the hit entry keeps its bit set. `hitRef` reports the bit as it stood before the edge.
- R4: A write hit without a violation sets the dirty bit of the entry at the next edge. `hitDirty` reports the dirty bit as it stood before the edge.
- R5: The rights codes are 0 read-only, 1 read/write, 2 executable and 3 no access. The access codes are 0 read, 1 write, 2 fetch and 3 read. Read-only permits reads only. Read/write permits reads and writes. Executable permits reads and fetches. No-access permits nothing. `violation` is 1 on a hit whose access is not permitted, and 0 otherwise.
- R6: A refill writes into the indexed set at the next edge. It uses an invalid way if there is one, way 0 first. Otherwise it uses a way whose referenced bit is 0, way 0 first. Otherwise it uses way 0. The walker refills only pages that are not already present.
- R7: A refilled entry starts valid, with dirty 0 and referenced 1, and holds the delivered tag, page number and rights.
- R8: `flush` invalidates every entry at the next edge. In that cycle it overrides any refill, reference clear or status update.
- R9: The lookup reflects the state before the coming edge. A refill, flush or status change becomes visible only in the cycle after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; all entries become invalid |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupVa | input | 40 | Virtual address to translate |
| lookupAccess | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| hit | output | 1 | A valid matching entry was found |
| violation | output | 1 | Hit whose access the entry's rights forbid |
| lookupPpn | output | 22 | Physical page number on a hit, otherwise 0 |
| lookupPa | output | 36 | Physical address on a hit, otherwise 0 |
| hitDirty | output | 1 | Dirty bit of the entry that hit |
| hitRef | output | 1 | Referenced bit of the entry that hit |
| refillValid | input | 1 | Write a new translation this cycle |
| refillVpn | input | 26 | Virtual page number of the new translation |
| refillPpn | input | 22 | Physical page number of the new translation |
| refillRights | input | 2 | Rights code of the new translation |
| clearRef | input | 1 | Clear every referenced bit |
| flush | input | 1 | Invalidate every entry |

## Verification
The bench builds the block with its default parameters: 256 sets, an 18-bit tag and a 14-bit offset. Those values make the address split checked at the ports the real one. The directed phase and the random phase both draw pages from a small pool of sets and tags. Many pages therefore collide in one set, so both ways fill up and replacement is exercised under every pattern of invalid, referenced and unreferenced ways. Set indices 0, 255 and a middle value are in the pool, so the edges of the index field are exercised. Clears, flushes and refills are also placed in the same cycle as lookups of the same page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int WAYS = 2;

  localparam logic [1:0] RIGHTS_RO   = 2'd0;
  localparam logic [1:0] RIGHTS_RW   = 2'd1;
  localparam logic [1:0] RIGHTS_EXEC = 2'd2;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  typedef struct packed {
    logic flushAll;
    logic clearRefAll;
    logic touchEn;
    logic touchWay;
    logic markDirty;
    logic fillEn;
    logic fillWay;
  } tlbStrobe_t;

  function automatic logic accessDenied(input logic [1:0] rights, input logic [1:0] acc);
    logic isWrite;
    logic isFetch;
    isWrite = (acc == ACC_WRITE);
    isFetch = (acc == ACC_FETCH);
    case (rights)
      RIGHTS_RO:   accessDenied = isWrite | isFetch;
      RIGHTS_RW:   accessDenied = isFetch;
      RIGHTS_EXEC: accessDenied = isWrite;
      default:     accessDenied = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int SET_BITS = 8,
  parameter int TAG_W    = 18,
  parameter int PPN_W    = 22
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  tlbStrobe_t                   strobe,
  input  logic [SET_BITS-1:0]          lookSet,
  input  logic [SET_BITS-1:0]          fillSet,
  input  logic [TAG_W-1:0]             fillTag,
  input  logic [PPN_W-1:0]             fillPpn,
  input  logic [1:0]                   fillRights,
  input  logic                         hitWay,
  output logic [WAYS-1:0]              lkValid,
  output logic [WAYS-1:0][TAG_W-1:0]   lkTag,
  output logic [WAYS-1:0][1:0]         lkRights,
  output logic [WAYS-1:0]              rfValid,
  output logic [WAYS-1:0]              rfRef,
  output logic [PPN_W-1:0]             selPpn,
  output logic                         selDirty,
  output logic                         selRef
);

  localparam int SETS = 1 << SET_BITS;

  logic [WAYS-1:0][PPN_W-1:0] lkPpn;
  logic [WAYS-1:0]            lkDirty;
  logic [WAYS-1:0]            lkRef;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  validQ;
    logic [SETS-1:0]  dirtyQ;
    logic [SETS-1:0]  refQ;
    logic [TAG_W-1:0] tagMem    [SETS];
    logic [PPN_W-1:0] ppnMem    [SETS];
    logic [1:0]       rightsMem [SETS];

    logic touchHere;
    logic fillHere;
    assign touchHere = strobe.touchEn && (strobe.touchWay == w[0]);
    assign fillHere  = strobe.fillEn  && (strobe.fillWay  == w[0]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ <= '0;
        dirtyQ <= '0;
        refQ   <= '0;
      end else if (strobe.flushAll) begin
        validQ <= '0;
      end else begin
        if (strobe.clearRefAll) refQ <= '0;
        if (touchHere) begin
          refQ[lookSet] <= 1'b1;
          if (strobe.markDirty) dirtyQ[lookSet] <= 1'b1;
        end
        if (fillHere) begin
          validQ[fillSet] <= 1'b1;
          dirtyQ[fillSet] <= 1'b0;
          refQ[fillSet]   <= 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (fillHere && !strobe.flushAll) begin
        tagMem[fillSet]    <= fillTag;
        ppnMem[fillSet]    <= fillPpn;
        rightsMem[fillSet] <= fillRights;
      end
    end

    assign lkValid[w]  = validQ[lookSet];
    assign lkTag[w]    = tagMem[lookSet];
    assign lkRights[w] = rightsMem[lookSet];
    assign lkPpn[w]    = ppnMem[lookSet];
    assign lkDirty[w]  = dirtyQ[lookSet];
    assign lkRef[w]    = refQ[lookSet];
    assign rfValid[w]  = validQ[fillSet];
    assign rfRef[w]    = refQ[fillSet];
  end

  assign selPpn   = lkPpn[hitWay];
  assign selDirty = lkDirty[hitWay];
  assign selRef   = lkRef[hitWay];

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int TAG_W = 18
) (
  input  logic                       lookupValid,
  input  logic [1:0]                 lookupAccess,
  input  logic [TAG_W-1:0]           lookTag,
  input  logic [WAYS-1:0]            lkValid,
  input  logic [WAYS-1:0][TAG_W-1:0] lkTag,
  input  logic [WAYS-1:0][1:0]       lkRights,
  input  logic                       refillValid,
  input  logic [WAYS-1:0]            rfValid,
  input  logic [WAYS-1:0]            rfRef,
  input  logic                       clearRef,
  input  logic                       flush,
  output tlbStrobe_t                 strobe,
  output logic                       hit,
  output logic                       hitWay,
  output logic                       violation
);

  logic [WAYS-1:0] match;
  logic            denied;
  logic            victim;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = lkValid[w] && (lkTag[w] == lookTag);
  end

  assign hit       = lookupValid && (|match);
  assign hitWay    = !match[0];
  assign denied    = accessDenied(lkRights[hitWay], lookupAccess);
  assign violation = hit && denied;

  always_comb begin
    if (!rfValid[0])      victim = 1'b0;
    else if (!rfValid[1]) victim = 1'b1;
    else if (!rfRef[0])   victim = 1'b0;
    else if (!rfRef[1])   victim = 1'b1;
    else                  victim = 1'b0;
  end

  always_comb begin
    strobe.flushAll    = flush;
    strobe.clearRefAll = clearRef;
    strobe.touchEn     = hit;
    strobe.touchWay    = hitWay;
    strobe.markDirty   = hit && (lookupAccess == ACC_WRITE) && !denied;
    strobe.fillEn      = refillValid;
    strobe.fillWay     = victim;
  end

endmodule

// File: rtl/tlb_sa.sv
module tlb_sa
  import tlb_pkg::*;
#(
  parameter int VA_W     = 40,
  parameter int PA_W     = 36,
  parameter int OFF_W    = 14,
  parameter int SET_BITS = 8,
  localparam int VPN_W   = VA_W - OFF_W,
  localparam int PPN_W   = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VA_W-1:0]  lookupVa,
  input  logic [1:0]       lookupAccess,
  output logic             hit,
  output logic             violation,
  output logic [PPN_W-1:0] lookupPpn,
  output logic [PA_W-1:0]  lookupPa,
  output logic             hitDirty,
  output logic             hitRef,
  input  logic             refillValid,
  input  logic [VPN_W-1:0] refillVpn,
  input  logic [PPN_W-1:0] refillPpn,
  input  logic [1:0]       refillRights,
  input  logic             clearRef,
  input  logic             flush
);

  localparam int TAG_W = VPN_W - SET_BITS;

  tlbStrobe_t                 strobe;
  logic [SET_BITS-1:0]        lookSet;
  logic [TAG_W-1:0]           lookTag;
  logic [WAYS-1:0]            lkValid;
  logic [WAYS-1:0][TAG_W-1:0] lkTag;
  logic [WAYS-1:0][1:0]       lkRights;
  logic [WAYS-1:0]            rfValid;
  logic [WAYS-1:0]            rfRef;
  logic                       hitWay;
  logic [PPN_W-1:0]           selPpn;
  logic                       selDirty;
  logic                       selRef;

  assign lookSet = lookupVa[OFF_W +: SET_BITS];
  assign lookTag = lookupVa[VA_W-1 -: TAG_W];

  tlb_store #(.SET_BITS(SET_BITS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
    .clk, .rstN, .strobe, .lookSet,
    .fillSet(refillVpn[SET_BITS-1:0]),
    .fillTag(refillVpn[VPN_W-1 -: TAG_W]),
    .fillPpn(refillPpn), .fillRights(refillRights), .hitWay,
    .lkValid, .lkTag, .lkRights, .rfValid, .rfRef,
    .selPpn, .selDirty, .selRef
  );

  tlb_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .lookupValid, .lookupAccess, .lookTag, .lkValid, .lkTag, .lkRights,
    .refillValid, .rfValid, .rfRef, .clearRef, .flush,
    .strobe, .hit, .hitWay, .violation
  );

  assign lookupPpn = hit ? selPpn : '0;
  assign lookupPa  = hit ? {selPpn, lookupVa[OFF_W-1:0]} : '0;
  assign hitDirty  = hit && selDirty;
  assign hitRef    = hit && selRef;

endmodule

// File: rtl/tlb_sa_chk.sv
module tlb_sa_chk #(
  parameter int VA_W  = 40,
  parameter int PA_W  = 36,
  parameter int OFF_W = 14,
  parameter int VPN_W = VA_W - OFF_W,
  parameter int PPN_W = PA_W - OFF_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             lookupValid,
  input logic [VA_W-1:0]  lookupVa,
  input logic             hit,
  input logic             violation,
  input logic [PPN_W-1:0] lookupPpn,
  input logic [PA_W-1:0]  lookupPa,
  input logic             hitRef,
  input logic             hitDirty,
  input logic             refillValid,
  input logic [VPN_W-1:0] refillVpn,
  input logic [PPN_W-1:0] refillPpn,
  input logic             flush
);

  assert_idle_no_hit_R1: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !hit);

  assert_offset_passes_R2: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (lookupPa[OFF_W-1:0] == lookupVa[OFF_W-1:0]) && (lookupPa[PA_W-1:OFF_W] == lookupPpn));

  assert_violation_on_hit_R5: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> hit);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !hit);

  assert_refill_visible_R7: assert property (@(posedge clk) disable iff (!rstN)
    (refillValid && !flush) |=>
      (!(lookupValid && (lookupVa[VA_W-1:OFF_W] == $past(refillVpn))) ||
       (hit && (lookupPpn == $past(refillPpn)) && hitRef && !hitDirty)));

endmodule

bind tlb_sa tlb_sa_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVa(lookupVa),
  .hit(hit), .violation(violation), .lookupPpn(lookupPpn), .lookupPa(lookupPa),
  .hitRef(hitRef), .hitDirty(hitDirty), .refillValid(refillValid),
  .refillVpn(refillVpn), .refillPpn(refillPpn), .flush(flush)
);

// File: tb/tb_tlb_sa.sv
module tb_tlb_sa;
  localparam int CLK_PERIOD = 10;
  localparam int NSETS = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [39:0] lookupVa = '0;
  logic [1:0]  lookupAccess = '0;
  logic        hit, violation, hitDirty, hitRef;
  logic [21:0] lookupPpn;
  logic [35:0] lookupPa;
  logic        refillValid = 1'b0;
  logic [25:0] refillVpn = '0;
  logic [21:0] refillPpn = '0;
  logic [1:0]  refillRights = '0;
  logic        clearRef = 1'b0;
  logic        flush = 1'b0;

  tlb_sa dut (
    .clk, .rstN, .lookupValid, .lookupVa, .lookupAccess, .hit, .violation,
    .lookupPpn, .lookupPa, .hitDirty, .hitRef, .refillValid, .refillVpn,
    .refillPpn, .refillRights, .clearRef, .flush
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural model: per set, two slots
  bit mValid [NSETS][2];
  bit mDirty [NSETS][2];
  bit mRef   [NSETS][2];
  int mTag   [NSETS][2];
  int mPpn   [NSETS][2];
  int mRights[NSETS][2];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit permitted(input int rights, input int acc);
    bit rd, wr, fe;
    rd = (acc == 0) || (acc == 3);
    wr = (acc == 1);
    fe = (acc == 2);
    if (rights == 0) return rd;
    if (rights == 1) return rd || wr;
    if (rights == 2) return rd || fe;
    return 0;
  endfunction

  function automatic int findSlot(input int set, input int tag);
    for (int w = 0; w < 2; w++)
      if (mValid[set][w] && mTag[set][w] == tag) return w;
    return -1;
  endfunction

  function automatic logic [39:0] mkVa(input int tag, input int set, input int off);
    return {tag[17:0], set[7:0], off[13:0]};
  endfunction

  // one clock: drive, compare against model mid-cycle, apply model at edge
  task automatic step(input bit lv, input logic [39:0] va, input int acc,
                      input bit rv, input logic [25:0] rvpn, input int rppn,
                      input int rr, input bit cr, input bit fl, input string req);
    int set, tag, slot, rset, rtag, vic, off;
    bit expHit, expViol;
    lookupValid = lv; lookupVa = va; lookupAccess = acc[1:0];
    refillValid = rv; refillVpn = rvpn; refillPpn = rppn[21:0];
    refillRights = rr[1:0]; clearRef = cr; flush = fl;
    #(CLK_PERIOD/4);
    off = int'(va[13:0]);
    set = int'(va[21:14]);
    tag = int'(va[39:22]);
    slot = lv ? findSlot(set, tag) : -1;
    expHit = (slot >= 0);
    check(hit == expHit, req, "hit", hit, expHit);
    if (expHit) begin
      expViol = !permitted(mRights[set][slot], acc);
      check(lookupPpn == mPpn[set][slot], "R2", "ppn", lookupPpn, mPpn[set][slot]);
      check(lookupPa == {mPpn[set][slot][21:0], va[13:0]}, "R2", "pa", lookupPa,
            {mPpn[set][slot][21:0], va[13:0]});
      check(violation == expViol, "R5", "violation", violation, expViol);
      check(hitDirty == mDirty[set][slot], "R4", "dirty", hitDirty, mDirty[set][slot]);
      check(hitRef == mRef[set][slot], "R3", "ref", hitRef, mRef[set][slot]);
    end else begin
      expViol = 0;
      check(lookupPpn == 0 && lookupPa == 0, "R1", "miss page", lookupPa, 0);
      check(violation == 0 && hitDirty == 0 && hitRef == 0, "R1", "miss flags",
            {violation, hitDirty, hitRef}, 0);
    end
    @(posedge clk);
    // R8: flush overrides everything this cycle
    if (fl) begin
      for (int s = 0; s < NSETS; s++) begin mValid[s][0] = 0; mValid[s][1] = 0; end
    end else begin
      rset = int'(rvpn[7:0]);
      rtag = int'(rvpn[25:8]);
      if (!mValid[rset][0]) vic = 0;
      else if (!mValid[rset][1]) vic = 1;
      else if (!mRef[rset][0]) vic = 0;
      else if (!mRef[rset][1]) vic = 1;
      else vic = 0;
      if (cr) for (int s = 0; s < NSETS; s++) begin mRef[s][0] = 0; mRef[s][1] = 0; end
      if (expHit) begin
        mRef[set][slot] = 1;
        if (acc == 1 && !expViol) mDirty[set][slot] = 1;
      end
      if (rv) begin
        mValid[rset][vic] = 1; mDirty[rset][vic] = 0; mRef[rset][vic] = 1;
        mTag[rset][vic] = rtag; mPpn[rset][vic] = rppn & 32'h3fffff; mRights[rset][vic] = rr;
      end
    end
    @(negedge clk);
  endtask

  task automatic look(input int tag, input int set, input int acc, input string req);
    step(1, mkVa(tag, set, 16'h1a5 + tag), acc, 0, '0, 0, 0, 0, 0, req);
  endtask

  task automatic fill(input int tag, input int set, input int ppn, input int rr, input string req);
    step(0, '0, 0, 1, {tag[17:0], set[7:0]}, ppn, rr, 0, 0, req);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int sets[4];
    int t, s, a;
    logic [25:0] rv;
    for (int i = 0; i < NSETS; i++)
      for (int w = 0; w < 2; w++) begin
        mValid[i][w] = 0; mDirty[i][w] = 0; mRef[i][w] = 0;
        mTag[i][w] = 0; mPpn[i][w] = 0; mRights[i][w] = 0;
      end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: empty after reset
    look(1, 5, 0, "R1");
    // R9: refill and lookup of the same page in one cycle still misses
    step(1, mkVa(1, 5, 7), 0, 1, {18'd1, 8'd5}, 'h12345, 1, 0, 0, "R9");
    look(1, 5, 0, "R2");
    look(1, 5, 1, "R4");
    look(1, 5, 0, "R4");
    // R7: second way filled, fresh status
    fill(2, 5, 'h00abc, 0, "R6");
    look(2, 5, 0, "R7");
    look(2, 5, 1, "R5");
    look(2, 5, 0, "R4");
    look(1, 5, 2, "R5");
    fill(1, 9, 'h3ffff0, 2, "R6");
    look(1, 9, 2, "R5");
    look(1, 9, 1, "R5");
    look(1, 9, 3, "R5");
    // R3: clear and hit in the same cycle, the hit wins
    step(1, mkVa(1, 5, 3), 0, 0, '0, 0, 0, 1, 0, "R3");
    look(1, 5, 0, "R3");
    step(0, '0, 0, 0, '0, 0, 0, 1, 0, "R3");
    look(1, 5, 0, "R3");
    // R6: way 1 unreferenced, replaced
    fill(3, 5, 'h2222, 1, "R6");
    look(2, 5, 0, "R6");
    look(3, 5, 0, "R6");
    // R6: both referenced, way 0 replaced
    fill(4, 5, 'h3333, 3, "R6");
    look(1, 5, 0, "R6");
    look(4, 5, 0, "R6");
    look(3, 5, 0, "R6");
    // R8: flush with refill and a lookup in the same cycle
    step(1, mkVa(4, 5, 0), 0, 1, {18'd7, 8'd0}, 'h77, 1, 1, 1, "R9");
    look(4, 5, 0, "R8");
    look(3, 5, 0, "R8");
    look(7, 0, 0, "R8");
    look(1, 9, 2, "R8");
    // random phase over a small colliding pool
    sets[0] = 0; sets[1] = 5; sets[2] = 131; sets[3] = 255;
    for (int n = 0; n < 4000; n++) begin
      bit doLook, doFill, doClr, doFl;
      int ft, fs, ra;
      t = $urandom_range(0, 4) + 100;
      s = sets[$urandom_range(0, 3)];
      a = $urandom_range(0, 3);
      doLook = ($urandom_range(0, 9) < 8);
      ft = $urandom_range(0, 4) + 100;
      fs = sets[$urandom_range(0, 3)];
      ra = $urandom_range(0, 3);
      doFill = ($urandom_range(0, 3) == 0) && (findSlot(fs, ft) < 0);
      doClr = ($urandom_range(0, 19) == 0);
      doFl = ($urandom_range(0, 99) == 0);
      rv = {ft[17:0], fs[7:0]};
      step(doLook, mkVa(t, s, $urandom_range(0, 16383)), a, doFill, rv,
           $urandom_range(0, 32'h3fffff), ra, doClr, doFl, "R6");
    end
    finished = 1;
    summary();
    $finish;
  end

endmodule